// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache Controller

This block sits between a processor request port and a word-wide main-memory port. Each word address is split into a tag, a set index and a word offset. Both ways of the indexed set are compared at once, and a hit completes in the same cycle that the request is presented. Read data appears combinationally on the response bus.

On a miss the controller picks a victim line in the set. If that line holds modified data, the controller first writes the whole line to memory. It then loads the full line that contains the requested word, reading the words in ascending order. The request that was held waiting then hits and completes. A write miss therefore allocates the line and merges the write as an ordinary write hit. Each line carries one recency bit, and the controller uses it to choose the victim.

Both ports use valid/ready. A processor request must hold `req_valid`, `req_write`, `req_addr` and `req_wdata` stable until a cycle in which `req_ready` is high; that cycle is the transfer. A memory command must hold `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` stable until `mem_ready` is high. Read data from memory returns on a later cycle, flagged by a one-cycle `mem_rvalid`.

Top module: `cache_ctrl_2way`

## Requirements
- R1: Address bit fields, low to high, are: word offset (log2 LINE_WORDS bits, bits [1:0] by default), set index (log2 SETS bits, bits [4:2] by default), and tag (the remaining upper bits). Memory addresses issued for a line are {tag, index, offset}.
- R2: When `req_valid` is high, a valid line in either way of the indexed set holds the request's tag, and the controller is idle, `req_ready` is high in that same cycle. For a read, `resp_rdata` carries the addressed word in that cycle. No memory command is issued.
- R3: On a miss, exactly LINE_WORDS memory reads are issued, at offsets 0 to LINE_WORDS-1 of the requested line in ascending order. The returned words then serve the request.
- R4: Fills go to an invalid way before any valid way, way 0 before way 1. A valid line in the other way of the set is kept.
- R5: When both ways are valid, the victim is the way whose recency bit is 0. A fill or a hit sets the touched way's bit to 1 and clears the other way's bit.
- R6: A write hit stores the data in the cache, marks the line modified, and issues no memory command. Memory keeps its old value.
- R7: A modified victim is written to memory in full, all LINE_WORDS words at its old tag's addresses, before the first fill read is issued.
- R8: `req_ready` stays low for the whole of a write-back and fill. A write miss completes after allocation with the written data merged, without a write-back of the new line.
- R9: Reset clears all valid, modified and recency bits, so the first access after reset misses and `req_ready` is low while no request is present.
- R10: A clean victim is replaced without any memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request transfers this cycle |
| resp_rdata | output | DATA_W | Read data, valid with req_ready on a read |
| mem_valid | output | 1 | Memory command present |
| mem_we | output | 1 | 1 = write-back word, 0 = fill read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Write-back data |
| mem_ready | input | 1 | Memory accepts the command |
| mem_rvalid | input | 1 | Fill word returned this cycle |
| mem_rdata | input | DATA_W | Fill word |

## Verification
A hit is due in the cycle the request is applied: the bench raises the request just after a falling edge and samples `req_ready` and `resp_rdata` a moment later, so a wait count of zero marks a hit. A miss becomes busy at the next rising edge. It then needs at least one cycle per written-back word, and two per fill word because of the memory's read latency. The bench counts the falling edges until `req_ready` rises and expects a nonzero count. Memory traffic is logged in order at each accepting edge of the bench's memory model, and the count, direction and addresses of that log are checked once each request has completed.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WB,
    ST_FILL_REQ,
    ST_FILL_WAIT
  } cstate_t;
endpackage

// File: rtl/cache_way.sv
module cache_way #(
  parameter int TAG_W  = 7,
  parameter int IDX_W  = 3,
  parameter int OFF_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [OFF_W-1:0]  lk_off,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_word,
  output logic              lk_valid,
  output logic              lk_dirty,
  output logic [TAG_W-1:0]  lk_line_tag,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_dirty,
  input  logic              fill_en,
  input  logic [TAG_W-1:0]  fill_tag
);
  localparam int SETS  = 1 << IDX_W;
  localparam int WORDS = 1 << OFF_W;

  logic [DATA_W-1:0] data_q [SETS][WORDS];
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [SETS-1:0]   valid_q;
  logic [SETS-1:0]   dirty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_en) begin
      valid_q[wr_idx] <= 1'b1;
      dirty_q[wr_idx] <= 1'b0;
    end else if (wr_en && wr_dirty) begin
      dirty_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) data_q[wr_idx][wr_off] <= wr_data;
    if (fill_en) tag_q[wr_idx] <= fill_tag;
  end

  assign lk_valid    = valid_q[lk_idx];
  assign lk_dirty    = dirty_q[lk_idx];
  assign lk_line_tag = tag_q[lk_idx];
  assign lk_hit      = lk_valid && (tag_q[lk_idx] == lk_tag);
  assign lk_word     = data_q[lk_idx][lk_off];

  a_r6_write_marks_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_dirty && !fill_en) |=> dirty_q[$past(wr_idx)]);

  a_r4_fill_valid_clean: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (valid_q[$past(wr_idx)] && !dirty_q[$past(wr_idx)]));
endmodule

// File: rtl/cache_use_bits.sv
module cache_use_bits #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic             touch_way,
  input  logic [IDX_W-1:0] lk_idx,
  output logic [1:0]       lk_use
);
  localparam int SETS = 1 << IDX_W;

  logic [1:0] use_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) use_q[s] <= 2'b00;
    end else if (touch_en) begin
      use_q[touch_idx] <= touch_way ? 2'b10 : 2'b01;
    end
  end

  assign lk_use = use_q[lk_idx];

  a_r5_use_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> $onehot(use_q[$past(touch_idx)]));
endmodule

// File: rtl/cache_ctrl_2way.sv
module cache_ctrl_2way
  import cache_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 16,
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int OFF_W = $clog2(LINE_WORDS);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam logic [OFF_W-1:0] LAST = OFF_W'(LINE_WORDS - 1);

  cstate_t state;
  logic [OFF_W-1:0] cnt;
  logic [IDX_W-1:0] miss_idx;
  logic [TAG_W-1:0] miss_tag, vic_tag;
  logic             vic_way;

  logic [OFF_W-1:0] req_off;
  logic [IDX_W-1:0] req_idx;
  logic [TAG_W-1:0] req_tag;
  assign req_off = req_addr[OFF_W-1:0];
  assign req_idx = req_addr[OFF_W +: IDX_W];
  assign req_tag = req_addr[ADDR_W-1 -: TAG_W];

  logic             idle;
  logic [IDX_W-1:0] lk_idx;
  logic [OFF_W-1:0] lk_off;
  assign idle   = (state == ST_IDLE);
  assign lk_idx = idle ? req_idx : miss_idx;
  assign lk_off = (state == ST_WB) ? cnt : req_off;

  logic [1:0]        hit, vld, drt, wr_en, fill_en;
  logic [DATA_W-1:0] word [2];
  logic [TAG_W-1:0]  ltag [2];
  logic [1:0]        use_bits;
  logic              hit_any, fill_done, victim;
  logic [OFF_W-1:0]  wr_off;
  logic [DATA_W-1:0] wr_data;

  assign hit_any   = |hit;
  assign req_ready = idle && req_valid && hit_any;
  assign resp_rdata = hit[1] ? word[1] : word[0];
  assign fill_done = (state == ST_FILL_WAIT) && mem_rvalid && (cnt == LAST);
  assign wr_off    = idle ? req_off : cnt;
  assign wr_data   = idle ? req_wdata : mem_rdata;

  always_comb begin
    if (!vld[0])      victim = 1'b0;
    else if (!vld[1]) victim = 1'b1;
    else              victim = use_bits[0];
  end

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign wr_en[w] = (req_ready && req_write && hit[w]) ||
                      ((state == ST_FILL_WAIT) && mem_rvalid && (vic_way == w));
    assign fill_en[w] = fill_done && (vic_way == w);
    cache_way #(.TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) i_way (
      .clk(clk), .rst_n(rst_n),
      .lk_idx(lk_idx), .lk_off(lk_off), .lk_tag(req_tag),
      .lk_hit(hit[w]), .lk_word(word[w]), .lk_valid(vld[w]), .lk_dirty(drt[w]),
      .lk_line_tag(ltag[w]),
      .wr_en(wr_en[w]), .wr_idx(lk_idx), .wr_off(wr_off), .wr_data(wr_data),
      .wr_dirty(idle), .fill_en(fill_en[w]), .fill_tag(miss_tag)
    );
  end

  cache_use_bits #(.IDX_W(IDX_W)) i_use (
    .clk(clk), .rst_n(rst_n),
    .touch_en(req_ready || fill_done), .touch_idx(lk_idx),
    .touch_way(idle ? hit[1] : vic_way),
    .lk_idx(lk_idx), .lk_use(use_bits)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      miss_idx <= '0;
      miss_tag <= '0;
      vic_tag  <= '0;
      vic_way  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid && !hit_any) begin
          miss_idx <= req_idx;
          miss_tag <= req_tag;
          vic_way  <= victim;
          vic_tag  <= ltag[victim];
          cnt      <= '0;
          state    <= (vld[victim] && drt[victim]) ? ST_WB : ST_FILL_REQ;
        end
        ST_WB: if (mem_ready) begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= ST_FILL_REQ;
        end
        ST_FILL_REQ: if (mem_ready) state <= ST_FILL_WAIT;
        ST_FILL_WAIT: if (mem_rvalid) begin
          cnt   <= cnt + 1'b1;
          state <= (cnt == LAST) ? ST_IDLE : ST_FILL_REQ;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_valid = (state == ST_WB) || (state == ST_FILL_REQ);
  assign mem_we    = (state == ST_WB);
  assign mem_addr  = {(state == ST_WB) ? vic_tag : miss_tag, miss_idx, cnt};
  assign mem_wdata = word[vic_way];

  a_r8_miss_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && req_valid && !req_ready) |=> !idle);

  a_r7_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_WB) && mem_ready && (cnt == LAST)) |=>
      ((state == ST_FILL_REQ) && (cnt == '0)));

  a_r3_hold_mem_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_we)));

  a_r2_one_way_hits: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $onehot0(hit));
endmodule

// File: tb/test_cache_ctrl_2way.sv
module test_cache_ctrl_2way;
  localparam int AW = 12;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready;
  logic [DW-1:0] resp_rdata;
  logic mem_valid, mem_we, mem_ready;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic mem_rvalid;

  always #4 clk = ~clk;

  cache_ctrl_2way i_cache_ctrl_2way (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .resp_rdata(resp_rdata),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata)
  );

  int n_checks = 0, n_fail = 0;
  logic [DW-1:0] mem [1<<AW];
  logic stall_en = 1'b0, tog = 1'b0;
  logic log_we [16];
  logic [AW-1:0] log_addr [16];
  int log_n = 0;

  assign mem_ready = !stall_en || tog;

  function automatic logic [DW-1:0] f_init(input logic [AW-1:0] a);
    return DW'(a * 7 + 16'h1357);
  endfunction
  function automatic logic [AW-1:0] mk(input int tag, input int idx, input int off);
    return {7'(tag), 3'(idx), 2'(off)};
  endfunction

  always @(posedge clk) begin
    tog <= ~tog;
    mem_rvalid <= 1'b0;
    if (rst_n && mem_valid && mem_ready) begin
      if (log_n < 16) begin
        log_we[log_n] <= mem_we;
        log_addr[log_n] <= mem_addr;
      end
      log_n <= log_n + 1;
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else begin
        mem_rvalid <= 1'b1;
        mem_rdata <= mem[mem_addr];
      end
    end
  end

  task automatic check(input logic ok, input string rq, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic clear_log();
    @(negedge clk);
    log_n = 0;
  endtask

  task automatic do_req(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        output logic [DW-1:0] rd, output int waits);
    @(negedge clk);
    req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = wd;
    waits = 0;
    #1;
    while (!req_ready && waits < 500) begin
      @(negedge clk); #1;
      waits++;
    end
    rd = resp_rdata;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic check_fill(input string rq, input int tag, input int idx, input int base);
    for (int k = 0; k < 4; k++) begin
      check(!log_we[base+k] && log_addr[base+k] == mk(tag, idx, k), rq,
            int'(log_addr[base+k]), int'(mk(tag, idx, k)));
    end
  endtask

  task automatic t_reset();
    logic [DW-1:0] rd; int w;
    check(req_ready === 1'b0, "R9 ready low after reset", int'(req_ready), 0);
    clear_log();
    do_req(1'b0, mk(5, 3, 2), '0, rd, w);
    check(w > 0, "R9 first access misses", w, 1);
    check(rd == f_init(mk(5, 3, 2)), "R3 fill data", int'(rd), int'(f_init(mk(5, 3, 2))));
    check(log_n == 4, "R3 four fill reads", log_n, 4);
    check_fill("R1 fill address order", 5, 3, 0);
  endtask

  task automatic t_hit();
    logic [DW-1:0] rd; int w;
    clear_log();
    do_req(1'b0, mk(5, 3, 1), '0, rd, w);
    check(w == 0, "R2 hit same cycle", w, 0);
    check(rd == f_init(mk(5, 3, 1)), "R2 hit data", int'(rd), int'(f_init(mk(5, 3, 1))));
    check(log_n == 0, "R2 no memory traffic", log_n, 0);
  endtask

  task automatic t_write_hit();
    logic [DW-1:0] rd; int w;
    clear_log();
    do_req(1'b1, mk(5, 3, 1), 16'hBEEF, rd, w);
    check(w == 0, "R6 write hit same cycle", w, 0);
    do_req(1'b0, mk(5, 3, 1), '0, rd, w);
    check(rd == 16'hBEEF, "R6 write data kept", int'(rd), 16'hBEEF);
    check(log_n == 0, "R6 no memory write", log_n, 0);
    check(mem[mk(5, 3, 1)] == f_init(mk(5, 3, 1)), "R6 memory unchanged",
          int'(mem[mk(5, 3, 1)]), int'(f_init(mk(5, 3, 1))));
  endtask

  task automatic t_second_way();
    logic [DW-1:0] rd; int w;
    clear_log();
    do_req(1'b0, mk(9, 3, 0), '0, rd, w);
    check(w > 0 && log_n == 4, "R4 fill into invalid way", log_n, 4);
    check_fill("R10 no write-back for invalid way", 9, 3, 0);
    do_req(1'b0, mk(5, 3, 1), '0, rd, w);
    check(w == 0 && rd == 16'hBEEF, "R4 way 0 line kept", int'(rd), 16'hBEEF);
    do_req(1'b0, mk(9, 3, 3), '0, rd, w);
    check(w == 0, "R4 way 1 hits", w, 0);
  endtask

  task automatic t_use_victim();
    logic [DW-1:0] rd; int w;
    do_req(1'b0, mk(5, 3, 0), '0, rd, w);
    clear_log();
    do_req(1'b0, mk(12, 3, 2), '0, rd, w);
    check(log_n == 4, "R5 clean LRU victim replaced", log_n, 4);
    check_fill("R10 clean victim no write", 12, 3, 0);
    do_req(1'b0, mk(5, 3, 3), '0, rd, w);
    check(w == 0, "R5 recently used line kept", w, 0);
    do_req(1'b0, mk(12, 3, 1), '0, rd, w);
  endtask

  task automatic t_writeback();
    logic [DW-1:0] rd; int w;
    clear_log();
    do_req(1'b0, mk(9, 3, 2), '0, rd, w);
    check(log_n == 8, "R7 write-back plus fill", log_n, 8);
    for (int k = 0; k < 4; k++) begin
      check(log_we[k] && log_addr[k] == mk(5, 3, k), "R7 write-back order",
            int'(log_addr[k]), int'(mk(5, 3, k)));
    end
    check_fill("R7 fill after write-back", 9, 3, 4);
    check(mem[mk(5, 3, 1)] == 16'hBEEF, "R7 modified word written",
          int'(mem[mk(5, 3, 1)]), 16'hBEEF);
    check(rd == f_init(mk(9, 3, 2)), "R7 new line data", int'(rd), int'(f_init(mk(9, 3, 2))));
    do_req(1'b0, mk(12, 3, 1), '0, rd, w);
    check(w == 0, "R5 MRU line survived", w, 0);
  endtask

  task automatic t_write_miss();
    logic [DW-1:0] rd; int w;
    clear_log();
    do_req(1'b1, mk(20, 6, 2), 16'hCAFE, rd, w);
    check(w > 0, "R8 ready low during fill", w, 1);
    check(log_n == 4, "R8 write miss allocates", log_n, 4);
    check_fill("R8 allocate reads", 20, 6, 0);
    do_req(1'b0, mk(20, 6, 2), '0, rd, w);
    check(w == 0 && rd == 16'hCAFE, "R8 write merged", int'(rd), 16'hCAFE);
    check(mem[mk(20, 6, 2)] == f_init(mk(20, 6, 2)), "R6 write miss stays cached",
          int'(mem[mk(20, 6, 2)]), int'(f_init(mk(20, 6, 2))));
  endtask

  task automatic t_stall();
    logic [DW-1:0] rd; int w;
    stall_en = 1'b1;
    clear_log();
    do_req(1'b0, mk(33, 1, 3), '0, rd, w);
    check(rd == f_init(mk(33, 1, 3)), "R3 data under memory stall",
          int'(rd), int'(f_init(mk(33, 1, 3))));
    check(w >= 8, "R8 ready low for whole fill", w, 8);
    check_fill("R3 fill order under stall", 33, 1, 0);
    stall_en = 1'b0;
  endtask

  initial begin
    for (int a = 0; a < (1 << AW); a++) mem[a] = f_init(AW'(a));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_hit();
    t_write_hit();
    t_second_way();
    t_use_victim();
    t_writeback();
    t_write_miss();
    t_stall();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule